// File: doc/BRIEF.md
# Boot-Overlay Address Decoder for a 68000-Family Board

This block is the glue logic between a 68000-family CPU and the memories and peripherals on a small single-board computer. It watches the 24-bit byte address, the address strobe, the data strobe and the read/write line. From these it drives one chip select for the ROM, one for the RAM and one for each of four peripheral slots. It also times the data-transfer acknowledge (DTACK) and raises a bus error when no device answers.

The peripherals sit in the top 32 KB of the map, so sign-extended 16-bit absolute addresses reach every one of them. Each slot's registers sit on even byte addresses only, two bytes apart, which suits byte-strided multi-register moves. ROM stays visible at all times through a high mirror window. After any reset a boot overlay is active. While it is on, reads in the low 64 KB return ROM data, so the CPU can fetch its reset vectors, but writes in the same range reach RAM. Reset code can therefore copy the vectors into RAM in place. It then writes the control register in the I/O region, which drops the overlay and puts RAM on both reads and writes at address zero.

Every mapped access is acknowledged by this decoder after a per-region wait count. Slow peripherals therefore need no E clock. An access that finds no target ends in a bus error.

Top module: `bootmap_decoder`

## Requirements
- R1: After reset, with the address strobe high, all chip selects are low, `dtack_n` and `berr_n` are high and `overlay_o` is 1.
- R2: While the overlay is on, a read below 0x010000 selects ROM and a write below 0x010000 selects RAM.
- R3: An access anywhere in 0xF00000–0xF7FFFF selects ROM, whatever the overlay state and the direction.
- R4: A write (rw=0) with the data strobe low to address 0xFFFF00 clears the overlay. A read of that address leaves the overlay unchanged. The control access asserts no chip select and is acknowledged after the I/O wait count.
- R5: With the overlay off, every access below 0x100000 selects RAM. Accesses in 0x010000–0x0FFFFF select RAM in either overlay state.
- R6: An even address 0xFF8000 + 0x100·n + k (n in 0..3, k < 0x100) asserts `io_cs[n]` only.
- R7: An odd address inside a slot window asserts no chip select and is still acknowledged after the I/O wait count.
- R8: DTACK goes low exactly ROM_WS, RAM_WS or IO_WS clock edges after the address strobe falls, according to the region. It goes high as soon as the address strobe rises.
- R9: An unmapped address (e.g. 0x100000–0xEFFFFF, 0xF80000–0xFF7FFF, or 0xFF8400–0xFFFFFF other than the control register) gets no DTACK. BERR goes low 64 clock edges after the address strobe falls and stays low until the strobe rises.
- R10: Chip selects are asserted only while the address strobe is low, and at most one is asserted at a time.
- R11: Any reset turns the overlay back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 24 | Byte address from the CPU |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| rom_cs | output | 1 | ROM select, active high |
| ram_cs | output | 1 | RAM select, active high |
| io_cs | output | 4 | Peripheral slot selects, active high |
| dtack_n | output | 1 | Transfer acknowledge to the CPU, active low |
| berr_n | output | 1 | Bus error to the CPU, active low |
| overlay_o | output | 1 | Current boot overlay state |

## Verification
The bench builds the decoder with ROM_WS=2, RAM_WS=0, IO_WS=3 and the default 64-clock timeout. The three distinct wait counts let a measured DTACK latency tell the regions apart. RAM_WS=0 exercises the acknowledge that arrives in the same cycle as the strobe, with no clock edge in between. The 64-clock timeout keeps each bus-error cycle short enough to repeat many times. Random cycles mixed with resets move the overlay back and forth, so the low region is seen in both overlay states.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

    localparam int IO_SLOTS   = 4;
    localparam int SLOT_IDX_W = $clog2(IO_SLOTS);

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_ROM,
        RGN_RAM,
        RGN_SLOT,
        RGN_SLOT_ODD,
        RGN_CTRL
    } region_e;

    typedef struct packed {
        region_e                 rgn;
        logic [SLOT_IDX_W-1:0]   slot;
    } decode_t;

    function automatic logic region_acks(region_e r);
        return r != RGN_NONE;
    endfunction

endpackage

// File: rtl/bootmap_addr_decode.sv
module bootmap_addr_decode
    import bootmap_pkg::*;
#(
    parameter int              ADDR_W         = 24,
    parameter int              IO_LOG2        = 15,
    parameter int              SLOT_SPAN_LOG2 = 8,
    parameter int              ROM_LOG2       = 19,
    parameter int              RAM_LOG2       = 20,
    parameter int              LOW_LOG2       = 16,
    parameter logic [ADDR_W-1:0] ROM_BASE     = 24'hF00000,
    parameter logic [IO_LOG2-1:0] CTRL_OFFSET = 15'h7F00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic              overlay,
    output decode_t           dec
);

    localparam int SLOT_TOP = SLOT_SPAN_LOG2 + SLOT_IDX_W;

    logic in_io, in_rom, in_ram, in_low, slot_hit;

    always_comb begin
        in_io    = &addr[ADDR_W-1:IO_LOG2];
        in_rom   = addr[ADDR_W-1:ROM_LOG2] == ROM_BASE[ADDR_W-1:ROM_LOG2];
        in_ram   = addr[ADDR_W-1:RAM_LOG2] == '0;
        in_low   = addr[RAM_LOG2-1:LOW_LOG2] == '0;
        slot_hit = addr[IO_LOG2-1:SLOT_TOP] == '0;
    end

    always_comb begin
        dec.rgn  = RGN_NONE;
        dec.slot = addr[SLOT_SPAN_LOG2 +: SLOT_IDX_W];
        if (in_io) begin
            if (addr[IO_LOG2-1:0] == CTRL_OFFSET)
                dec.rgn = RGN_CTRL;
            else if (slot_hit)
                dec.rgn = addr[0] ? RGN_SLOT_ODD : RGN_SLOT;
        end else if (in_rom) begin
            dec.rgn = RGN_ROM;
        end else if (in_ram) begin
            // low reads come from ROM while the overlay is on; writes go to RAM
            dec.rgn = (in_low && overlay && rw) ? RGN_ROM : RGN_RAM;
        end
    end

endmodule

// File: rtl/bootmap_overlay.sv
module bootmap_overlay (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_write,
    output logic overlay
);

    always_ff @(posedge clk) begin
        if (rst)
            overlay <= 1'b1;
        else if (ctrl_write)
            overlay <= 1'b0;
    end

    AST_OVL_AFTER_RESET: assert property (@(posedge clk) rst |=> overlay); // R11
    AST_OVL_STAYS_OFF: assert property (@(posedge clk) disable iff (rst)
        !overlay |=> !overlay); // R4

endmodule

// File: rtl/bootmap_ack_timer.sv
module bootmap_ack_timer #(
    parameter int TIMEOUT = 64,
    parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             as_n,
    input  logic             ack_ok,
    input  logic [CNT_W-1:0] wait_cnt,
    output logic             dtack_n,
    output logic             berr_n
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || as_n)
            cnt <= '0;
        else if (cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        dtack_n = !(!as_n && ack_ok && cnt >= wait_cnt);
        berr_n  = !(!as_n && dtack_n && cnt >= LIMIT);
    end

    AST_BERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!berr_n && !as_n) |=> (as_n || !berr_n)); // R9
    AST_DTACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!dtack_n && !as_n) |=> (as_n || !dtack_n)); // R8
    AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        as_n |-> (dtack_n && berr_n)); // R8

endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
    import bootmap_pkg::*;
#(
    parameter int ROM_WS  = 3,
    parameter int RAM_WS  = 1,
    parameter int IO_WS   = 2,
    parameter int TIMEOUT = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [23:0]         addr_i,
    input  logic                as_n,
    input  logic                ds_n,
    input  logic                rw,
    output logic                rom_cs,
    output logic                ram_cs,
    output logic [IO_SLOTS-1:0] io_cs,
    output logic                dtack_n,
    output logic                berr_n,
    output logic                overlay_o
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);

    decode_t          dec;
    logic             overlay;
    logic             ctrl_write;
    logic [CNT_W-1:0] wait_sel;

    initial begin
        AST_WAIT_FITS: assert (ROM_WS < TIMEOUT && RAM_WS < TIMEOUT && IO_WS < TIMEOUT); // R8
    end

    bootmap_addr_decode #(.ADDR_W(24)) u_dec (
        .addr    (addr_i),
        .rw      (rw),
        .overlay (overlay),
        .dec     (dec)
    );

    assign ctrl_write = !as_n && !ds_n && !rw && dec.rgn == RGN_CTRL;

    bootmap_overlay u_ovl (
        .clk        (clk),
        .rst        (rst),
        .ctrl_write (ctrl_write),
        .overlay    (overlay)
    );

    always_comb begin
        unique case (dec.rgn)
            RGN_ROM: wait_sel = CNT_W'(ROM_WS);
            RGN_RAM: wait_sel = CNT_W'(RAM_WS);
            default: wait_sel = CNT_W'(IO_WS);
        endcase
    end

    bootmap_ack_timer #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_ack (
        .clk      (clk),
        .rst      (rst),
        .as_n     (as_n),
        .ack_ok   (region_acks(dec.rgn)),
        .wait_cnt (wait_sel),
        .dtack_n  (dtack_n),
        .berr_n   (berr_n)
    );

    assign rom_cs    = !as_n && dec.rgn == RGN_ROM;
    assign ram_cs    = !as_n && dec.rgn == RGN_RAM;
    assign overlay_o = overlay;

    for (genvar s = 0; s < IO_SLOTS; s++) begin : g_slot
        assign io_cs[s] = !as_n && dec.rgn == RGN_SLOT && dec.slot == SLOT_IDX_W'(s);
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_cs, ram_cs, io_cs})); // R10
    AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        as_n |-> !(rom_cs || ram_cs || |io_cs)); // R10
    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!dtack_n && !berr_n)); // R9

endmodule

// File: tb/bootmap_decoder_test.sv
`timescale 1ns/1ps
module bootmap_decoder_test;

    localparam int ROM_WS = 2, RAM_WS = 0, IO_WS = 3, TMO = 64;

    logic        clk = 1'b0, rst = 1'b1;
    logic [23:0] addr_i = '0;
    logic        as_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
    logic        rom_cs, ram_cs, dtack_n, berr_n, overlay_o;
    logic [3:0]  io_cs;

    int  n_tests = 0, n_fail = 0;
    logic m_ovl = 1'b1;
    bit  done = 0;

    always #2.5 clk = ~clk;

    bootmap_decoder #(.ROM_WS(ROM_WS), .RAM_WS(RAM_WS), .IO_WS(IO_WS), .TIMEOUT(TMO)) uut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .as_n(as_n), .ds_n(ds_n), .rw(rw),
        .rom_cs(rom_cs), .ram_cs(ram_cs), .io_cs(io_cs),
        .dtack_n(dtack_n), .berr_n(berr_n), .overlay_o(overlay_o));

    function automatic bit is_ctrl(logic [23:0] a);
        return a == 24'hFFFF00;
    endfunction

    function automatic bit is_slot(logic [23:0] a);
        return a >= 24'hFF8000 && a < 24'hFF8400;
    endfunction

    // {rom, ram, io[3:0]}
    function automatic logic [5:0] exp_cs(logic [23:0] a, logic r, logic ovl);
        if (is_slot(a)) return a[0] ? 6'b0 : (6'b1 << a[9:8]);
        if (a >= 24'hFF8000) return 6'b0;
        if (a >= 24'hF00000 && a < 24'hF80000) return 6'b100000;
        if (a < 24'h010000) return (ovl && r) ? 6'b100000 : 6'b010000;
        if (a < 24'h100000) return 6'b010000;
        return 6'b0;
    endfunction

    function automatic int exp_wait(logic [23:0] a, logic r, logic ovl);
        logic [5:0] c = exp_cs(a, r, ovl);
        if (is_ctrl(a) || is_slot(a)) return IO_WS;
        if (c[5]) return ROM_WS;
        if (c[4]) return RAM_WS;
        return -1;
    endfunction

    function automatic string tag_of(logic [23:0] a);
        if (is_ctrl(a)) return "R4";
        if (is_slot(a)) return a[0] ? "R7" : "R6";
        if (a >= 24'hF00000 && a < 24'hF80000) return "R3";
        if (a < 24'h010000) return m_ovl ? "R2" : "R5";
        if (a < 24'h100000) return "R5";
        return "R9";
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; as_n = 1'b1; ds_n = 1'b1;
        @(negedge clk); rst = 1'b0; m_ovl = 1'b1;
        #0.5;
        check(overlay_o == 1'b1, "R11", "overlay after reset", overlay_o, 1);
    endtask

    task automatic bus_cycle(logic [23:0] a, logic r);
        int n = 0;
        int ew = exp_wait(a, r, m_ovl);
        string t = tag_of(a);
        @(negedge clk);
        addr_i = a; rw = r; as_n = 1'b0; ds_n = 1'b0;
        #0.5;
        check({rom_cs, ram_cs, io_cs} == exp_cs(a, r, m_ovl), t, "chip selects",
              {rom_cs, ram_cs, io_cs}, exp_cs(a, r, m_ovl));
        while (dtack_n && berr_n && n < TMO + 8) begin
            @(negedge clk); #0.5; n++;
        end
        if (ew >= 0)
            check(!dtack_n && berr_n && n == ew, "R8", "dtack latency", n, ew);
        else
            check(dtack_n && !berr_n && n == TMO, "R9", "berr latency", n, TMO);
        @(negedge clk); #0.5;
        if (ew < 0) check(!berr_n && dtack_n, "R9", "berr held", berr_n, 0);
        @(negedge clk);
        as_n = 1'b1; ds_n = 1'b1;
        #0.5;
        check(dtack_n && berr_n && {rom_cs, ram_cs, io_cs} == 6'b0, "R10",
              "release on strobe high", {dtack_n, berr_n, rom_cs, ram_cs, io_cs}, 8'hC0);
        if (is_ctrl(a) && !r) m_ovl = 1'b0;
        if (is_ctrl(a))
            check(overlay_o == m_ovl, "R4", "overlay after control access", overlay_o, m_ovl);
    endtask

    function automatic logic [23:0] rand_addr();
        logic [23:0] x = 24'($urandom);
        case ($urandom_range(0, 7))
            0: return {8'h00, x[15:0]};
            1: return 24'h010000 + (x % 24'h0F0000);
            2: return {5'b11110, x[18:0]};
            3: return {14'h3FE0, x[9:1], 1'b0};
            4: return {14'h3FE0, x[9:1], 1'b1};
            5: return 24'h100000 + (x % 24'hE00000);
            6: return 24'hFF8400 + {12'h0, x[11:0]};
            default: return 24'hFFFF00;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #0.5;
        check({rom_cs, ram_cs, io_cs} == 6'b0 && dtack_n && berr_n && overlay_o, "R1",
              "reset state", {rom_cs, ram_cs, io_cs, dtack_n, berr_n, overlay_o}, 9'h007);
        // directed: overlay on
        bus_cycle(24'h000000, 1'b1);   // R2 vector read from ROM
        bus_cycle(24'h000004, 1'b0);   // R2 write goes to RAM
        bus_cycle(24'h00FFFE, 1'b1);   // R2 top of low region
        bus_cycle(24'h010000, 1'b1);   // R5 just above low region
        bus_cycle(24'hF00000, 1'b0);   // R3 mirror
        bus_cycle(24'hF7FFFF, 1'b1);   // R3
        bus_cycle(24'hFF8000, 1'b1);   // R6 slot 0
        bus_cycle(24'hFF8102, 1'b0);   // R6 slot 1
        bus_cycle(24'hFF8202, 1'b1);   // R6 slot 2
        bus_cycle(24'hFF83FE, 1'b1);   // R6 slot 3
        bus_cycle(24'hFF8001, 1'b1);   // R7 odd byte
        bus_cycle(24'h100000, 1'b1);   // R9 unmapped
        bus_cycle(24'hF80000, 1'b1);   // R9
        bus_cycle(24'hFF8400, 1'b0);   // R9
        bus_cycle(24'hFFFF00, 1'b1);   // R4 read keeps overlay
        bus_cycle(24'h000000, 1'b1);   // R2 still ROM
        bus_cycle(24'hFFFF00, 1'b0);   // R4 clears overlay
        bus_cycle(24'h000000, 1'b1);   // R5 RAM at zero
        bus_cycle(24'hF00010, 1'b1);   // R3 mirror still ROM
        do_reset();                    // R11
        bus_cycle(24'h000000, 1'b1);   // R11 ROM again at zero
        for (int i = 0; i < 80; i++) begin
            if ($urandom_range(0, 15) == 0) do_reset();
            bus_cycle(rand_addr(), 1'($urandom_range(0, 1)));
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule